// File: doc/BRIEF.md
# Nibble-Serial Packet Receiver with Skid Buffer

This block receives packets from a sender that transfers one valid bit and four data bits per clock. It builds them into a 128-bit packet word. A shadow shift register of valid bits runs beside a nibble shift register. When the oldest valid bit turns on after being off, a full packet sits in the word, and the block raises `pkt_rdy`. Packets are 32 nibbles long. Consecutive packets need at least one idle (valid low) beat between them.

Downstream logic drives `stall_req` whenever it cannot take another packet. While `stall_req` is high, the assembly registers hold. The block registers `stall_req` once and sends it to the sender as `stall_out`. The sender holds its current beat while it sees `stall_out` high. The stall takes one cycle to reach the sender, and the input register adds one more cycle of delay. During that window two beats arrive that cannot be shifted in. A two-entry skid store keeps them, and a replay multiplexer feeds them back in order once the stall ends.

The control uses two small state machines. The boot machine (`BOOT_COLD` → `BOOT_WARM` → `BOOT_LIVE`, then stays in `BOOT_LIVE`) keeps the input valid register closed for the first two clocks after reset. The skid machine has three states:
- `SK_FLOW` is the resting state.
- It moves to `SK_CATCH1` in the cycle after a stall begins, when the second skid entry loads.
- It moves to `SK_REPLAY1` in the cycle after a stall ends, when the second entry is replayed.
- Otherwise it returns to `SK_FLOW`.

Top module: `nib_rx`

## Requirements
- R1: A synchronous active-high reset clears `stall_out`, `pkt_rdy`, the valid shadow, the skid valid bits and the boot machine. After reset, `stall_out` and `pkt_rdy` read 0.
- R2: `stall_out` equals the value `stall_req` had one clock earlier.
- R3: Valid bits on the first two clock edges after reset release are discarded. The beat offered on the third edge is the first one that can start a packet.
- R4: The block takes a beat from the sender on every edge where `stall_out` was low. The sender holds its beat while `stall_out` is high, and the block takes no new beat then.
- R5: Beats already in flight when a stall begins go into the skid store. After the stall ends they are replayed ahead of later beats, so no beat is lost, duplicated or reordered.
- R6: The valid shadow and `pkt_word` advance only on edges where `stall_req` is low. On other edges `pkt_word` keeps its value.
- R7: Each advance shifts the new nibble into `pkt_word[127:124]` and moves every older nibble down by four bits. At `pkt_rdy`, the first nibble of the packet is in `pkt_word[3:0]`.
- R8: `pkt_rdy` is high when the oldest shadow bit is 1 and was 0 before the most recent advance. It stays high while `stall_req` holds the assembly, and it drops after the next advance.
- R9: Between two stalls, `stall_req` must stay low for at least two consecutive cycles.
- R10: Every 32-nibble packet that is separated from the next by at least one idle beat appears at `pkt_word` intact, in order and exactly once. A packet counts as delivered on a cycle where `pkt_rdy` is high and `stall_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Beat valid from the sender |
| in_nib | input | 4 | Beat data nibble from the sender |
| stall_out | output | 1 | Registered stall sent back to the sender |
| stall_req | input | 1 | Stall request from downstream buffering |
| pkt_rdy | output | 1 | A complete packet is present in `pkt_word` |
| pkt_word | output | 128 | Assembled packet, oldest nibble in bits [3:0] |

## Verification
The bench looks for the following corner cases:
- **Stall edges and length.** Stalls rise one beat before, during and after packet boundaries. They last from a single cycle up to six cycles, often with the minimum two-cycle gap. A skid that loaded the wrong entry, or replayed its entries in the wrong order, would shift, lose or repeat a nibble. That shows up as a wrong `pkt_word` or a missing packet.
- **Packet boundaries.** A `pkt_rdy` held across a stall would be counted twice, or lost, if the edge detector advanced when the shadow did not. Single idle gaps between packets catch a detector that needs a longer run of zeros.
- **Boot window.** A packet begins exactly at reset release. A ready chain one cycle too short or too long moves its first nibble away from 0x2.

// File: rtl/nib_rx_pkg.sv
package nib_rx_pkg;

    // Boot sequencing: input valid capture opens only in BOOT_LIVE
    typedef enum logic [1:0] {
        BOOT_COLD = 2'd0,
        BOOT_WARM = 2'd1,
        BOOT_LIVE = 2'd2
    } boot_e;

    // Skid sequencing: second skid entry load and second replay slot
    typedef enum logic [1:0] {
        SK_FLOW    = 2'd0,
        SK_CATCH1  = 2'd1,
        SK_REPLAY1 = 2'd2
    } skid_e;

endpackage

// File: rtl/nib_rx_front.sv
module nib_rx_front
    import nib_rx_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [NIB_W-1:0] in_nib,
    input  logic             stall_req,
    output logic             stall_q,
    output logic             cap_vld,
    output logic [NIB_W-1:0] cap_nib,
    output boot_e            boot_state
);

    boot_e boot_next;
    logic  stall_d1;
    logic  live;

    // boot state register
    always_ff @(posedge clk) begin
        if (rst) boot_state <= BOOT_COLD;
        else     boot_state <= boot_next;
    end

    // boot next-state and outputs
    always_comb begin
        boot_next = boot_state;
        live      = 1'b0;
        unique case (boot_state)
            BOOT_COLD: boot_next = BOOT_WARM;
            BOOT_WARM: boot_next = BOOT_LIVE;
            BOOT_LIVE: begin
                boot_next = BOOT_LIVE;
                live      = 1'b1;
            end
            default:   boot_next = BOOT_COLD;
        endcase
    end

    // stall toward the sender and its one-cycle delayed copy
    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q  <= 1'b0;
            stall_d1 <= 1'b0;
        end else begin
            stall_q  <= stall_req;
            stall_d1 <= stall_q;
        end
    end

    // input valid register: closed during boot and while the delayed stall is high
    always_ff @(posedge clk) begin
        if (rst)                 cap_vld <= 1'b0;
        else if (!stall_d1 && live) cap_vld <= in_vld;
    end

    // input data register: no reset needed
    always_ff @(posedge clk) begin
        if (!stall_d1) cap_nib <= in_nib;
    end

endmodule

// File: rtl/nib_rx_skid.sv
module nib_rx_skid
    import nib_rx_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall_req,
    input  logic             stall_q,
    input  logic             cap_vld,
    input  logic [NIB_W-1:0] cap_nib,
    output logic             out_vld,
    output logic [NIB_W-1:0] out_nib
);

    localparam int ENTRIES = 2;

    skid_e phase, phase_next;
    logic  catch0, replay0;
    logic  catch1, replay1;
    logic [ENTRIES-1:0] wr_en;
    logic [ENTRIES-1:0] ent_vld;
    logic [NIB_W-1:0]   ent_nib [ENTRIES];

    // stall rising (request up, sender not yet told) and falling
    assign catch0  = stall_req & ~stall_q;
    assign replay0 = ~stall_req & stall_q;

    // phase state register
    always_ff @(posedge clk) begin
        if (rst) phase <= SK_FLOW;
        else     phase <= phase_next;
    end

    // phase transitions and decoded outputs
    always_comb begin
        catch1  = 1'b0;
        replay1 = 1'b0;
        unique case (phase)
            SK_FLOW:    ;
            SK_CATCH1:  catch1  = 1'b1;
            SK_REPLAY1: replay1 = 1'b1;
            default:    ;
        endcase
        if (catch0)       phase_next = SK_CATCH1;
        else if (replay0) phase_next = SK_REPLAY1;
        else              phase_next = SK_FLOW;
    end

    assign wr_en = {catch1, catch0};

    // skid entries
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)           ent_vld[g] <= 1'b0;
            else if (wr_en[g]) ent_vld[g] <= cap_vld;
        end
        always_ff @(posedge clk) begin
            if (wr_en[g]) ent_nib[g] <= cap_nib;
        end
    end

    // replay multiplexer
    always_comb begin
        if (replay0) begin
            out_vld = ent_vld[0];
            out_nib = ent_nib[0];
        end else if (replay1) begin
            out_vld = ent_vld[1];
            out_nib = ent_nib[1];
        end else begin
            out_vld = cap_vld;
            out_nib = cap_nib;
        end
    end

endmodule

// File: rtl/nib_rx_asm.sv
module nib_rx_asm #(
    parameter int NIB_W    = 4,
    parameter int PKT_NIBS = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      stall_req,
    input  logic                      beat_vld,
    input  logic [NIB_W-1:0]          beat_nib,
    output logic                      pkt_rdy,
    output logic [NIB_W*PKT_NIBS-1:0] pkt_word
);

    localparam int WORD_W = NIB_W * PKT_NIBS;

    logic                advance;
    logic [PKT_NIBS-1:0] shadow;
    logic                oldest_prev;

    assign advance = ~stall_req;

    // valid shadow and edge-detect history
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow      <= '0;
            oldest_prev <= 1'b0;
        end else if (advance) begin
            shadow      <= {beat_vld, shadow[PKT_NIBS-1:1]};
            oldest_prev <= shadow[0];
        end
    end

    // nibble shift register, newest at the top
    always_ff @(posedge clk) begin
        if (advance) pkt_word <= {beat_nib, pkt_word[WORD_W-1:NIB_W]};
    end

    assign pkt_rdy = shadow[0] & ~oldest_prev;

endmodule

// File: rtl/nib_rx.sv
module nib_rx
    import nib_rx_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int PKT_NIBS = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_vld,
    input  logic [NIB_W-1:0]          in_nib,
    output logic                      stall_out,
    input  logic                      stall_req,
    output logic                      pkt_rdy,
    output logic [NIB_W*PKT_NIBS-1:0] pkt_word
);

    logic             cap_vld;
    logic [NIB_W-1:0] cap_nib;
    logic             mux_vld;
    logic [NIB_W-1:0] mux_nib;
    boot_e            boot_state;
    logic             boot_live;

    assign boot_live = (boot_state == BOOT_LIVE);

    nib_rx_front #(.NIB_W(NIB_W)) u_front (
        .clk        (clk),
        .rst        (rst),
        .in_vld     (in_vld),
        .in_nib     (in_nib),
        .stall_req  (stall_req),
        .stall_q    (stall_out),
        .cap_vld    (cap_vld),
        .cap_nib    (cap_nib),
        .boot_state (boot_state)
    );

    nib_rx_skid #(.NIB_W(NIB_W)) u_skid (
        .clk       (clk),
        .rst       (rst),
        .stall_req (stall_req),
        .stall_q   (stall_out),
        .cap_vld   (cap_vld),
        .cap_nib   (cap_nib),
        .out_vld   (mux_vld),
        .out_nib   (mux_nib)
    );

    nib_rx_asm #(.NIB_W(NIB_W), .PKT_NIBS(PKT_NIBS)) u_asm (
        .clk       (clk),
        .rst       (rst),
        .stall_req (stall_req),
        .beat_vld  (mux_vld),
        .beat_nib  (mux_nib),
        .pkt_rdy   (pkt_rdy),
        .pkt_word  (pkt_word)
    );

endmodule

// File: rtl/nib_rx_chk.sv
module nib_rx_chk #(
    parameter int WORD_W = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              stall_req,
    input logic              stall_out,
    input logic              pkt_rdy,
    input logic [WORD_W-1:0] pkt_word,
    input logic              boot_live,
    input logic              cap_vld
);

    AST_STALL_COPY: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (stall_out == $past(stall_req))); // R2

    AST_STALL_SPACING: assert property (@(posedge clk) disable iff (rst)
        $fell(stall_req) |=> !stall_req); // R9

    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        stall_req |=> $stable(pkt_word)); // R6

    AST_RDY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (pkt_rdy && !stall_req) |=> !pkt_rdy); // R8

    AST_RDY_HELD: assert property (@(posedge clk) disable iff (rst)
        (pkt_rdy && stall_req) |=> pkt_rdy); // R8

    AST_BOOT_GATE: assert property (@(posedge clk) disable iff (rst)
        !boot_live |=> !cap_vld); // R3

endmodule

bind nib_rx nib_rx_chk #(.WORD_W(NIB_W*PKT_NIBS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall_req (stall_req),
    .stall_out (stall_out),
    .pkt_rdy   (pkt_rdy),
    .pkt_word  (pkt_word),
    .boot_live (boot_live),
    .cap_vld   (cap_vld)
);

// File: tb/sim_nib_rx.sv
`timescale 1ns/1ps
module sim_nib_rx;
    localparam int NW = 4;
    localparam int NP = 32;
    localparam int WW = NW * NP;
    localparam int NPKT = 120;

    typedef struct packed {
        logic       v;
        logic [3:0] n;
    } beat_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_vld = 1'b0;
    logic [NW-1:0] in_nib = '0;
    logic          stall_req = 1'b0;
    logic          stall_out;
    logic          pkt_rdy;
    logic [WW-1:0] pkt_word;

    nib_rx #(.NIB_W(NW), .PKT_NIBS(NP)) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (in_vld),
        .in_nib    (in_nib),
        .stall_out (stall_out),
        .stall_req (stall_req),
        .pkt_rdy   (pkt_rdy),
        .pkt_word  (pkt_word)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    beat_t         tx[$];
    beat_t         pipe[$];
    beat_t         hist[$];
    logic [WW-1:0] expq[$];
    logic          prev0;
    logic          exp_stall;
    int            boot_n;
    int            stall_left;
    int            gap;
    bit            boot_seen;
    logic [WW-1:0] last_word;
    logic          last_stall;

    task automatic chk(input bit ok, input string tag,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] hist_word();
        logic [WW-1:0] w;
        w = '0;
        for (int i = 0; i < NP; i++) w[i*NW +: NW] = hist[i].n;
        return w;
    endfunction

    initial begin
        beat_t b;
        logic [WW-1:0] pw;
        logic exp_rdy;
        // boot packet: nibble i carries i mod 16, starts at reset release
        for (int i = 0; i < NP; i++) begin
            b.v = 1'b1; b.n = 4'(i); tx.push_back(b);
        end
        for (int i = 0; i < 3; i++) tx.push_back('0);
        // scored packets with idle gaps of 1..4 beats
        for (int p = 0; p < NPKT; p++) begin
            for (int i = 0; i < NP; i++) begin
                b.v = 1'b1; b.n = 4'($urandom_range(0, 15));
                pw[i*NW +: NW] = b.n;
                tx.push_back(b);
            end
            expq.push_back(pw);
            for (int g = 0; g < int'($urandom_range(1, 4)); g++) tx.push_back('0);
        end
        for (int i = 0; i < 40; i++) tx.push_back('0);

        // model reset state
        pipe.push_back('0);
        for (int i = 0; i < NP; i++) hist.push_back('0);
        prev0 = 1'b0; exp_stall = 1'b0; boot_n = 0;
        stall_left = 0; gap = 0; boot_seen = 1'b0;
        last_stall = 1'b0; last_word = '0;

        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(stall_out === 1'b0, "R1 stall_out after reset", WW'(stall_out), '0);
        chk(pkt_rdy === 1'b0, "R1 pkt_rdy after reset", WW'(pkt_rdy), '0);
        rst = 1'b0;

        for (int cyc = 0; cyc < 30000; cyc++) begin
            if (tx.size() == 0 && expq.size() == 0) break;
            // compare outputs against the model
            exp_rdy = hist[0].v & ~prev0;
            chk(stall_out === exp_stall, "R2 stall_out", WW'(stall_out), WW'(exp_stall));
            chk(pkt_rdy === exp_rdy, "R8 pkt_rdy", WW'(pkt_rdy), WW'(exp_rdy));
            if (exp_rdy) chk(pkt_word === hist_word(), "R7 pkt_word", pkt_word, hist_word());
            if (last_stall && cyc > 0) chk(pkt_word === last_word, "R6 word held", pkt_word, last_word);
            last_word = pkt_word;

            // stall generator, low at least two cycles between stalls
            if (stall_left > 0) begin
                stall_req = 1'b1; stall_left--; gap = 0;
            end else begin
                stall_req = 1'b0; gap++;
                if (gap >= 2 && $urandom_range(0, 5) == 0) stall_left = $urandom_range(1, 6);
            end
            last_stall = stall_req;

            // sender drives its current beat
            b = (tx.size() != 0) ? tx[0] : beat_t'('0);
            in_vld = b.v; in_nib = b.n;

            // delivery on this edge
            if (exp_rdy && !stall_req) begin
                if (!boot_seen) begin
                    boot_seen = 1'b1;
                    chk(pkt_word[7:0] === 8'h32, "R3 first kept nibbles", WW'(pkt_word[7:0]), WW'(8'h32));
                end else if (expq.size() == 0) begin
                    chk(1'b0, "R10 unexpected packet", pkt_word, '0);
                end else begin
                    pw = expq.pop_front();
                    chk(pkt_word === pw, "R4 R5 R10 packet", pkt_word, pw);
                end
            end

            // model transition for the coming edge
            if (!stall_req) begin
                if (pipe.size() == 0) chk(1'b0, "R5 beat missing", '0, '1);
                else begin
                    prev0 = hist[0].v;
                    void'(hist.pop_front());
                    hist.push_back(pipe.pop_front());
                end
            end
            if (!exp_stall) begin
                b.v = in_vld && (boot_n >= 2);
                b.n = in_nib;
                pipe.push_back(b);
                if (tx.size() != 0) void'(tx.pop_front());
            end
            boot_n++;
            exp_stall = stall_req;
            @(negedge clk);
        end
        if (expq.size() != 0) chk(1'b0, "R10 packets missing", WW'(expq.size()), '0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule